// File: doc/BRIEF.md
# Frame Receive Classifier with CRC Check

This block sits behind a link receiver that has already decoded and aligned the serial stream into 32-bit words. Each word comes with a flag that marks it as a control character. The block finds frame boundaries in this stream. It runs a CRC-32 over each frame, reads the frame header to decide whether the frame carries data or link control (an acknowledgement, for example), and sends the frame's results to two places. The payload words go to a receive buffer write port. A one-record-per-frame descriptor (type, payload length, CRC verdict) goes out on a separate valid/ready stream.

Payload is written speculatively, starting at the buffer's committed boundary. That boundary, `pb_commit_ptr`, moves forward only when the frame's CRC matches. A frame that fails, or that is cut short by a new start-of-frame, rolls the write pointer back, so the next frame overwrites its words. A saturating error counter records every failed or aborted frame.

The input is a valid/ready stream and the descriptor output is a valid/ready stream. Back-pressure rule: while a descriptor is pending and `desc_ready` is low, `in_ready` is low and no input word is accepted. The payload port is a plain write port with no handshake. The consumer reads only the region below `pb_commit_ptr`.

Top module: `frx_classifier`

## Requirements
- R1: After reset, `in_ready`=1, `desc_valid`=0, `pb_we`=0, `in_frame`=0, `err_count`=0 and `pb_commit_ptr`=0.
- R2: A word with `in_ctrl`=1 and `in_data`=32'h3CA55A01 opens a frame. A word with `in_ctrl`=1 and `in_data`=32'h3CA55AFE closes it. Every other control word, and every word arriving outside a frame, is ignored: it causes no buffer write, no descriptor and no counter change.
- R3: The first data word after the frame opens is the header. If header bits [31:28] equal 4'hC the frame is a control frame (`desc_ctrl`=1); any other value makes it a data frame (`desc_ctrl`=0).
- R4: The last data word before the close is the received CRC. The running CRC-32 uses polynomial 0x04C11DB7, processed most-significant bit first, with an all-ones seed and no reflection or final inversion. It covers the header and the payload words. `desc_crc_ok`=1 exactly when the two values are equal.
- R5: Payload words (those between the header and the CRC) are written in arrival order to consecutive addresses, starting at `pb_commit_ptr` and wrapping modulo 2^AW. `pb_commit_ptr` advances by the payload count only for a frame whose CRC is good. After a failed frame, the next frame's payload starts at the same address.
- R6: Each accepted close inside a frame produces exactly one descriptor, carrying the type, the payload word count and the CRC verdict. A frame of fewer than two data words gives a descriptor with type 0, length 0 and `desc_crc_ok`=0.
- R7: `err_count` goes up by one, saturating, for each frame that closes with a bad CRC, each frame too short to hold a header and a CRC, and each aborted frame.
- R8: An open word that arrives inside an open frame aborts that frame: no descriptor is produced, its payload is rolled back, and a new frame begins.
- R9: While `desc_valid`=1 and `desc_ready`=0, the descriptor fields hold steady and `in_ready`=0.
- R10: `in_frame` is 1 from the cycle after an open word is accepted until the cycle after a close word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high together with in_valid |
| in_data | input | 32 | Received word |
| in_ctrl | input | 1 | Word is a control character |
| pb_we | output | 1 | Payload buffer write enable |
| pb_addr | output | AW | Payload buffer write address |
| pb_data | output | 32 | Payload buffer write data |
| pb_commit_ptr | output | AW | First address past committed payload |
| desc_valid | output | 1 | Descriptor record valid |
| desc_ready | input | 1 | Descriptor sink ready |
| desc_ctrl | output | 1 | 1 = control frame, 0 = data frame |
| desc_len | output | LW | Payload word count |
| desc_crc_ok | output | 1 | CRC matched |
| err_count | output | EW | Saturating count of failed and aborted frames |
| in_frame | output | 1 | A frame is open |

## Verification
The bench drives frames with a good CRC and frames with one flipped CRC bit. It then checks that a failed frame leaves the commit boundary where it was and that the next good frame's payload lands on the same addresses. A design that committed before checking, or forgot the rollback, would leave holes or stale words in the buffer. It cuts a partly written frame short with a new open word and checks that no descriptor appears and the error count goes up. A design that treated the open word as data or emitted a record would be caught. Runt frames must not be reported as good with a garbage length. Descriptor stalls must freeze both the record and the input, and a design that kept accepting words would lose a record. Idle and stray words outside a frame must leave every output untouched.

// File: rtl/frx_pkg.sv
package frx_pkg;
  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

  typedef enum logic [1:0] {
    W_IDLE = 2'd0,
    W_DATA = 2'd1,
    W_SOF  = 2'd2,
    W_EOF  = 2'd3
  } word_kind_e;
endpackage

// File: rtl/frx_word_decode.sv
module frx_word_decode
  import frx_pkg::*;
#(
  parameter logic [31:0] SOF_CODE = 32'h3CA5_5A01,
  parameter logic [31:0] EOF_CODE = 32'h3CA5_5AFE
) (
  input  logic        is_ctrl,
  input  logic [31:0] word,
  output word_kind_e  kind
);
  always_comb begin
    if (!is_ctrl)              kind = W_DATA;
    else if (word == SOF_CODE) kind = W_SOF;
    else if (word == EOF_CODE) kind = W_EOF;
    else                       kind = W_IDLE;
  end
endmodule

// File: rtl/frx_crc32_step.sv
module frx_crc32_step
  import frx_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [31:0]   crc_in,
  input  logic [DW-1:0] din,
  output logic [31:0]   crc_out
);
  always_comb begin
    logic [31:0] acc;
    logic        fb;
    acc = crc_in;
    for (int i = DW - 1; i >= 0; i--) begin
      fb  = acc[31] ^ din[i];
      acc = {acc[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
    end
    crc_out = acc;
  end
endmodule

// File: rtl/frx_ptr_pair.sv
module frx_ptr_pair #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic          commit,
  input  logic          rollback,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] commit_ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      commit_ptr <= '0;
    end else begin
      if (rollback)     wr_ptr <= commit_ptr;
      else if (advance) wr_ptr <= wr_ptr + 1'b1;
      if (commit)       commit_ptr <= wr_ptr;
    end
  end
endmodule

// File: rtl/frx_classifier.sv
module frx_classifier
  import frx_pkg::*;
#(
  parameter int          AW       = 6,
  parameter int          LW       = 8,
  parameter int          EW       = 16,
  parameter logic [31:0] SOF_CODE = 32'h3CA5_5A01,
  parameter logic [31:0] EOF_CODE = 32'h3CA5_5AFE,
  parameter logic [3:0]  CTRL_NIB = 4'hC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [31:0]   in_data,
  input  logic          in_ctrl,
  output logic          pb_we,
  output logic [AW-1:0] pb_addr,
  output logic [31:0]   pb_data,
  output logic [AW-1:0] pb_commit_ptr,
  output logic          desc_valid,
  input  logic          desc_ready,
  output logic          desc_ctrl,
  output logic [LW-1:0] desc_len,
  output logic          desc_crc_ok,
  output logic [EW-1:0] err_count,
  output logic          in_frame
);
  localparam logic [EW-1:0] ERR_MAX = {EW{1'b1}};

  word_kind_e    kind;
  logic          fire;
  logic          open_q, pend_v_q, hdr_done_q, is_ctrl_q;
  logic [31:0]   pend_q, crc_q, crc_nxt;
  logic [LW-1:0] len_q;
  logic [AW-1:0] wr_ptr;
  logic          pend_proc, wr_payload, eof_hit, abort, frame_ok, fail;

  frx_word_decode #(.SOF_CODE(SOF_CODE), .EOF_CODE(EOF_CODE)) u_dec (
    .is_ctrl(in_ctrl), .word(in_data), .kind(kind)
  );

  frx_crc32_step #(.DW(32)) u_crc (
    .crc_in(crc_q), .din(pend_q), .crc_out(crc_nxt)
  );

  assign in_ready   = !desc_valid || desc_ready;
  assign fire       = in_valid && in_ready;
  assign pend_proc  = fire && (kind == W_DATA) && open_q && pend_v_q;
  assign wr_payload = pend_proc && hdr_done_q;
  assign eof_hit    = fire && (kind == W_EOF) && open_q;
  assign abort      = fire && (kind == W_SOF) && open_q;
  assign frame_ok   = pend_v_q && hdr_done_q && (crc_q == pend_q);
  assign fail       = abort || (eof_hit && !frame_ok);

  frx_ptr_pair #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .advance(wr_payload),
    .commit(eof_hit && frame_ok),
    .rollback(fail),
    .wr_ptr(wr_ptr),
    .commit_ptr(pb_commit_ptr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q      <= 1'b0;
      pend_v_q    <= 1'b0;
      hdr_done_q  <= 1'b0;
      is_ctrl_q   <= 1'b0;
      pend_q      <= '0;
      crc_q       <= CRC_SEED;
      len_q       <= '0;
      pb_we       <= 1'b0;
      pb_addr     <= '0;
      pb_data     <= '0;
      desc_valid  <= 1'b0;
      desc_ctrl   <= 1'b0;
      desc_len    <= '0;
      desc_crc_ok <= 1'b0;
      err_count   <= '0;
    end else begin
      pb_we <= wr_payload;
      if (wr_payload) begin
        pb_addr <= wr_ptr;
        pb_data <= pend_q;
      end

      if (desc_valid && desc_ready) desc_valid <= 1'b0;
      if (eof_hit) begin
        desc_valid  <= 1'b1;
        desc_ctrl   <= is_ctrl_q;
        desc_len    <= len_q;
        desc_crc_ok <= frame_ok;
      end

      if (fail && err_count != ERR_MAX) err_count <= err_count + 1'b1;

      if (fire) begin
        unique case (kind)
          W_SOF: begin
            open_q     <= 1'b1;
            pend_v_q   <= 1'b0;
            hdr_done_q <= 1'b0;
            is_ctrl_q  <= 1'b0;
            len_q      <= '0;
            crc_q      <= CRC_SEED;
          end
          W_EOF: open_q <= 1'b0;
          W_DATA: begin
            if (open_q) begin
              pend_q   <= in_data;
              pend_v_q <= 1'b1;
              if (pend_v_q) begin
                crc_q <= crc_nxt;
                if (!hdr_done_q) begin
                  hdr_done_q <= 1'b1;
                  is_ctrl_q  <= (pend_q[31:28] == CTRL_NIB);
                end else begin
                  len_q <= len_q + 1'b1;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign in_frame = open_q;
endmodule

// File: rtl/frx_classifier_chk.sv
module frx_classifier_chk #(
  parameter int AW = 6,
  parameter int LW = 8,
  parameter int EW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          pb_we,
  input logic          in_frame,
  input logic [AW-1:0] pb_commit_ptr,
  input logic          desc_valid,
  input logic          desc_ready,
  input logic          desc_ctrl,
  input logic [LW-1:0] desc_len,
  input logic          desc_crc_ok,
  input logic [EW-1:0] err_count
);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && !desc_ready |=> desc_valid && $stable(desc_len) &&
    $stable(desc_ctrl) && $stable(desc_crc_ok));

  // R9
  no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && !desc_ready |-> !in_ready);

  // R5
  commit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pb_commit_ptr) |-> desc_valid && desc_crc_ok);

  // R7
  err_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_count >= $past(err_count));

  // R5
  write_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pb_we |-> in_frame);
endmodule

bind frx_classifier frx_classifier_chk #(.AW(AW), .LW(LW), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .pb_we(pb_we),
  .in_frame(in_frame), .pb_commit_ptr(pb_commit_ptr),
  .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_ctrl(desc_ctrl),
  .desc_len(desc_len), .desc_crc_ok(desc_crc_ok), .err_count(err_count)
);

// File: tb/tb_frx_classifier.sv
`timescale 1ns/1ps
module tb_frx_classifier;
  localparam int AW = 6;
  localparam int LW = 8;
  localparam int EW = 16;
  localparam logic [31:0] SOF = 32'h3CA5_5A01;
  localparam logic [31:0] EOF = 32'h3CA5_5AFE;
  localparam logic [31:0] IDL = 32'h3CB5_B5B5;

  typedef struct packed {
    logic [3:0] nib;
    logic [3:0] plen;
    logic       bad;
    logic       idle_mid;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{4'h1, 4'd3, 1'b0, 1'b0},
    '{4'hC, 4'd0, 1'b0, 1'b1},
    '{4'h2, 4'd5, 1'b1, 1'b0},
    '{4'h3, 4'd2, 1'b0, 1'b1},
    '{4'hC, 4'd1, 1'b0, 1'b0},
    '{4'hD, 4'd4, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ctrl = 1'b0, desc_ready = 1'b1;
  logic [31:0] in_data = '0;
  logic in_ready, pb_we, desc_valid, desc_ctrl, desc_crc_ok, in_frame;
  logic [AW-1:0] pb_addr, pb_commit_ptr;
  logic [31:0] pb_data;
  logic [LW-1:0] desc_len;
  logic [EW-1:0] err_count;

  always #2 clk = ~clk;

  frx_classifier #(.AW(AW), .LW(LW), .EW(EW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_ctrl(in_ctrl), .pb_we(pb_we), .pb_addr(pb_addr),
    .pb_data(pb_data), .pb_commit_ptr(pb_commit_ptr), .desc_valid(desc_valid),
    .desc_ready(desc_ready), .desc_ctrl(desc_ctrl), .desc_len(desc_len),
    .desc_crc_ok(desc_crc_ok), .err_count(err_count), .in_frame(in_frame)
  );

  int checks = 0, errors = 0;
  int desc_cnt = 0, wr_cnt = 0;
  logic cap_ctrl, cap_ok;
  logic [LW-1:0] cap_len;
  logic [31:0] mem [1 << AW];
  logic [31:0] pay [16];
  logic [AW-1:0] exp_commit = '0;
  logic [EW-1:0] exp_err = '0;
  bit done = 0;

  always @(negedge clk) begin
    if (desc_valid && desc_ready) begin
      desc_cnt++;
      cap_ctrl = desc_ctrl;
      cap_len  = desc_len;
      cap_ok   = desc_crc_ok;
    end
    if (pb_we) begin
      mem[pb_addr] = pb_data;
      wr_cnt++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [31:0] w);
    logic [31:0] r;
    logic t;
    r = c;
    for (int b = 31; b >= 0; b--) begin
      t = r[31] ^ w[b];
      r = r << 1;
      if (t) r = r ^ 32'h04C1_1DB7;
    end
    return r;
  endfunction

  task automatic put(input logic c, input logic [31:0] d);
    in_valid = 1'b1; in_ctrl = c; in_data = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_frame(input logic [3:0] nib, input int plen, input bit bad,
                            input bit idle_mid, input int tag);
    logic [31:0] hdr, c;
    hdr = {nib, 28'h0ABCDE0} ^ 32'(tag);
    c = ref_crc(32'hFFFF_FFFF, hdr);
    put(1'b1, SOF);
    put(1'b0, hdr);
    for (int j = 0; j < plen; j++) begin
      pay[j] = 32'h1000_0000 * tag + 32'(j * 3 + 1);
      c = ref_crc(c, pay[j]);
      put(1'b0, pay[j]);
      if (idle_mid && j == 0) put(1'b1, IDL);
    end
    if (idle_mid && plen == 0) put(1'b1, IDL);
    put(1'b0, bad ? (c ^ 32'h1) : c);
    put(1'b1, EOF);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic check_payload(input string req, input logic [AW-1:0] base, input int plen);
    int bad_words;
    bad_words = 0;
    for (int j = 0; j < plen; j++)
      if (mem[AW'(base + AW'(j))] !== pay[j]) bad_words++;
    check(req, 32'(bad_words), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int d0, w0;
    logic [AW-1:0] base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 in_ready", in_ready, 1);
    check("R1 desc_valid", desc_valid, 0);
    check("R1 pb_we", pb_we, 0);
    check("R1 in_frame", in_frame, 0);
    check("R1 err_count", err_count, 0);
    check("R1 commit", pb_commit_ptr, 0);

    // Table-driven frames: R3 R4 R5 R6 R7
    for (int v = 0; v < 6; v++) begin
      d0 = desc_cnt;
      base = exp_commit;
      send_frame(VECS[v].nib, int'(VECS[v].plen), VECS[v].bad, VECS[v].idle_mid, v + 1);
      check("R6 one descriptor", desc_cnt, d0 + 1);
      check("R3 type", cap_ctrl, VECS[v].nib == 4'hC);
      check("R6 length", cap_len, 32'(VECS[v].plen));
      check("R4 crc verdict", cap_ok, !VECS[v].bad);
      if (!VECS[v].bad) exp_commit = exp_commit + AW'(VECS[v].plen);
      else exp_err++;
      check("R5 commit pointer", pb_commit_ptr, exp_commit);
      check("R7 error count", err_count, exp_err);
      if (!VECS[v].bad) check_payload("R5 payload words", base, int'(VECS[v].plen));
    end

    // R2: idle and stray words outside a frame are ignored
    d0 = desc_cnt; w0 = wr_cnt;
    put(1'b1, IDL); put(1'b0, 32'hDEAD_BEEF); put(1'b1, EOF); put(1'b0, 32'h1234_5678);
    @(negedge clk); @(negedge clk);
    check("R2 no descriptor", desc_cnt, d0);
    check("R2 no write", wr_cnt, w0);
    check("R2 no error", err_count, exp_err);
    check("R2 commit held", pb_commit_ptr, exp_commit);
    check("R2 frame closed", in_frame, 0);

    // R10 in_frame rises after open word
    put(1'b1, SOF);
    check("R10 in_frame open", in_frame, 1);
    // R8 abort: header plus payload then a new open word
    put(1'b0, 32'h1000_0000); put(1'b0, 32'hAAAA_0001);
    put(1'b0, 32'hAAAA_0002); put(1'b0, 32'hAAAA_0003);
    d0 = desc_cnt;
    base = exp_commit;
    send_frame(4'h5, 2, 1'b0, 1'b0, 9);
    exp_err++;
    exp_commit = exp_commit + AW'(2);
    check("R8 abort no extra descriptor", desc_cnt, d0 + 1);
    check("R8 abort counted", err_count, exp_err);
    check("R8 rollback commit", pb_commit_ptr, exp_commit);
    check_payload("R8 rollback overwrite", base, 2);
    check("R10 in_frame closed", in_frame, 0);

    // R6 runt frame: one data word only
    d0 = desc_cnt;
    put(1'b1, SOF); put(1'b0, 32'hC000_0000); put(1'b1, EOF);
    @(negedge clk); @(negedge clk);
    exp_err++;
    check("R6 runt descriptor", desc_cnt, d0 + 1);
    check("R6 runt type", cap_ctrl, 0);
    check("R6 runt length", cap_len, 0);
    check("R6 runt crc", cap_ok, 0);
    check("R7 runt counted", err_count, exp_err);
    check("R5 runt commit", pb_commit_ptr, exp_commit);

    // R9 descriptor back-pressure
    desc_ready = 1'b0;
    d0 = desc_cnt;
    send_frame(4'h6, 1, 1'b0, 1'b0, 11);
    exp_commit = exp_commit + AW'(1);
    check("R9 desc held valid", desc_valid, 1);
    check("R9 input stalled", in_ready, 0);
    check("R9 length held", desc_len, 1);
    repeat (3) @(negedge clk);
    check("R9 still stalled", in_ready, 0);
    check("R9 not consumed", desc_cnt, d0);
    desc_ready = 1'b1;
    @(negedge clk);
    check("R9 consumed once", desc_cnt, d0 + 1);
    @(negedge clk);
    check("R9 valid dropped", desc_valid, 0);
    check("R9 ready restored", in_ready, 1);
    check("R5 commit after stall", pb_commit_ptr, exp_commit);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule